// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits beside a two-port shared memory and watches the access traffic of both ports, side A and side B. It does not store data. It decides when one side has left a message for the other and raises an interrupt toward the receiver. Each side owns one reserved mailbox word. Side A posts to the top word of the address space, and side B posts to the word just below it. A write by the owner to its mailbox pulls the other side's interrupt low. A read of that word by the receiver releases the interrupt.

Every access is sampled on the rising clock edge. A flag changes on that edge, so the interrupt outputs come straight from registers and are active low. A synchronous active-high reset returns both interrupts to high. If a post and a release of the same flag arrive in the same cycle, the post wins. This keeps a new message from being lost while the previous one is being collected.

Top module: `mbx_irq`

## Requirements
- R1: While `rst` is high at a rising edge, both `a_irq_n` and `b_irq_n` are 1 after that edge. Reset overrides any access in the same cycle.
- R2: An access on side A with `a_en`=1, `a_we`=1 and `a_addr`=0x7FF (A's mailbox) makes `b_irq_n` 0 after that edge.
- R3: An access on side B with `b_en`=1, `b_we`=1 and `b_addr`=0x7FE (B's mailbox) makes `a_irq_n` 0 after that edge.
- R4: A read on side B with `b_en`=1, `b_oe`=1, `b_we`=0 and `b_addr`=0x7FF makes `b_irq_n` 1 after that edge, unless R8 applies.
- R5: A read on side A with `a_en`=1, `a_oe`=1, `a_we`=0 and `a_addr`=0x7FE makes `a_irq_n` 1 after that edge, unless R8 applies.
- R6: A receiver access at the peer mailbox does not release the flag if any of these holds: enable is 0, output enable is 0, or write enable is 1.
- R7: An access with enable 0, or with an address that is not a mailbox, neither posts nor releases a flag.
- R8: When a post and a release of the same flag occur in the same cycle, the flag is asserted (output 0) after the edge.
- R9: A side's read or write of its own mailbox never changes its own interrupt output.
- R10: A flag with neither a post nor a release in a cycle keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_en | input | 1 | Side A access enable, active high |
| a_we | input | 1 | Side A write enable, active high |
| a_oe | input | 1 | Side A output (read) enable, active high |
| a_addr | input | 11 | Side A word address |
| b_en | input | 1 | Side B access enable, active high |
| b_we | input | 1 | Side B write enable, active high |
| b_oe | input | 1 | Side B output (read) enable, active high |
| b_addr | input | 11 | Side B word address |
| a_irq_n | output | 1 | Interrupt toward side A, active low, registered |
| b_irq_n | output | 1 | Interrupt toward side B, active low, registered |

## Verification
The bench applies each partial release in turn: enable off, output enable off, and write enable on. A design that decoded only the address would drop the interrupt early on one of these. It also drives a post and a release of the same flag together, once while the flag is idle and once while it is pending. If release won that race, the new message would be lost. Accesses to a side's own mailbox, and to the word next to a mailbox, catch swapped mailbox constants and address comparisons that ignore the low bits. A reset asserted during a post checks that reset has priority.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NSIDES = 2;
  localparam int SIDE_A = 0;
  localparam int SIDE_B = 1;

  function automatic int other_side(input int s);
    return (NSIDES - 1) - s;
  endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int AW = 11,
  parameter logic [AW-1:0] OWN_BOX  = '1,
  parameter logic [AW-1:0] PEER_BOX = '0
) (
  input  logic          en,
  input  logic          we,
  input  logic          oe,
  input  logic [AW-1:0] addr,
  output logic          post,
  output logic          collect
);
  logic hit_own, hit_peer;

  always_comb begin
    hit_own  = (addr == OWN_BOX);
    hit_peer = (addr == PEER_BOX);
    // a write to the owner's box raises the other side's flag
    post     = en && we && hit_own;
    // only a true read of the peer box releases this side's flag
    collect  = en && oe && !we && hit_peer;
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst)       pend <= 1'b0;
    else if (set)  pend <= 1'b1;
    else if (clr)  pend <= 1'b0;
  end

  assign irq_n = ~pend;
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int AW = 11,
  localparam logic [AW-1:0] BOX_A = {AW{1'b1}},
  localparam logic [AW-1:0] BOX_B = {AW{1'b1}} - 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_en,
  input  logic          a_we,
  input  logic          a_oe,
  input  logic [AW-1:0] a_addr,
  input  logic          b_en,
  input  logic          b_we,
  input  logic          b_oe,
  input  logic [AW-1:0] b_addr,
  output logic          a_irq_n,
  output logic          b_irq_n
);
  import mbx_pkg::*;

  logic          en_v   [NSIDES];
  logic          we_v   [NSIDES];
  logic          oe_v   [NSIDES];
  logic [AW-1:0] addr_v [NSIDES];
  logic          post_v [NSIDES];
  logic          coll_v [NSIDES];
  logic          irq_v  [NSIDES];

  always_comb begin
    en_v[SIDE_A] = a_en;   en_v[SIDE_B] = b_en;
    we_v[SIDE_A] = a_we;   we_v[SIDE_B] = b_we;
    oe_v[SIDE_A] = a_oe;   oe_v[SIDE_B] = b_oe;
    addr_v[SIDE_A] = a_addr;
    addr_v[SIDE_B] = b_addr;
  end

  for (genvar s = 0; s < NSIDES; s++) begin : g_side
    localparam int PEER = other_side(s);
    localparam logic [AW-1:0] OWN_BOX  = (s == SIDE_A) ? BOX_A : BOX_B;
    localparam logic [AW-1:0] PEER_BOX = (s == SIDE_A) ? BOX_B : BOX_A;

    mbx_decode #(.AW(AW), .OWN_BOX(OWN_BOX), .PEER_BOX(PEER_BOX)) u_dec (
      .en     (en_v[s]),
      .we     (we_v[s]),
      .oe     (oe_v[s]),
      .addr   (addr_v[s]),
      .post   (post_v[s]),
      .collect(coll_v[s])
    );

    mbx_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .set  (post_v[PEER]),
      .clr  (coll_v[s]),
      .irq_n(irq_v[s])
    );
  end

  assign a_irq_n = irq_v[SIDE_A];
  assign b_irq_n = irq_v[SIDE_B];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          a_en,
  input logic          a_we,
  input logic          a_oe,
  input logic [AW-1:0] a_addr,
  input logic          b_en,
  input logic          b_we,
  input logic          b_oe,
  input logic [AW-1:0] b_addr,
  input logic          a_irq_n,
  input logic          b_irq_n
);
  localparam logic [AW-1:0] TOP_W  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT_W = {AW{1'b1}} - 1'b1;

  logic a_posts, b_posts, a_reads, b_reads;
  assign a_posts = a_en && a_we && (a_addr == TOP_W);
  assign b_posts = b_en && b_we && (b_addr == NEXT_W);
  assign a_reads = a_en && a_oe && !a_we && (a_addr == NEXT_W);
  assign b_reads = b_en && b_oe && !b_we && (b_addr == TOP_W);

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (a_irq_n && b_irq_n));
  a_r2_a_post: assert property (@(posedge clk) disable iff (rst) a_posts |=> !b_irq_n);
  a_r3_b_post: assert property (@(posedge clk) disable iff (rst) b_posts |=> !a_irq_n);
  a_r4_b_collect: assert property (@(posedge clk) disable iff (rst)
    (b_reads && !a_posts) |=> b_irq_n);
  a_r5_a_collect: assert property (@(posedge clk) disable iff (rst)
    (a_reads && !b_posts) |=> a_irq_n);
  a_r10_a_hold: assert property (@(posedge clk) disable iff (rst)
    (!b_posts && !a_reads) |=> $stable(a_irq_n));
  a_r10_b_hold: assert property (@(posedge clk) disable iff (rst)
    (!a_posts && !b_reads) |=> $stable(b_irq_n));
endmodule

bind mbx_irq mbx_irq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst),
  .a_en(a_en), .a_we(a_we), .a_oe(a_oe), .a_addr(a_addr),
  .b_en(b_en), .b_we(b_we), .b_oe(b_oe), .b_addr(b_addr),
  .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
);

// File: tb/mbx_irq_bench.sv
`timescale 1ns/1ps
module mbx_irq_bench;
  localparam int AW = 11;

  typedef struct packed {
    logic          ae, awe, aoe;
    logic [AW-1:0] aa;
    logic          be, bwe, boe;
    logic [AW-1:0] ba;
    logic          exp_a, exp_b;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,11'h000, 1'b0,1'b0,1'b0,11'h000, 1'b1,1'b1, 4'd10}, // R10 idle
    '{1'b1,1'b1,1'b0,11'h7FF, 1'b0,1'b0,1'b0,11'h000, 1'b1,1'b0, 4'd2},  // R2 A posts
    '{1'b0,1'b0,1'b0,11'h000, 1'b0,1'b0,1'b0,11'h000, 1'b1,1'b0, 4'd10}, // R10 held
    '{1'b0,1'b0,1'b0,11'h000, 1'b1,1'b1,1'b1,11'h7FF, 1'b1,1'b0, 4'd6},  // R6 we set
    '{1'b0,1'b0,1'b0,11'h000, 1'b0,1'b0,1'b1,11'h7FF, 1'b1,1'b0, 4'd6},  // R6 en off
    '{1'b0,1'b0,1'b0,11'h000, 1'b1,1'b0,1'b0,11'h7FF, 1'b1,1'b0, 4'd6},  // R6 oe off
    '{1'b0,1'b0,1'b0,11'h000, 1'b1,1'b0,1'b1,11'h7FE, 1'b1,1'b0, 4'd9},  // R9 B reads own box
    '{1'b0,1'b0,1'b0,11'h000, 1'b1,1'b0,1'b1,11'h7FF, 1'b1,1'b1, 4'd4},  // R4 B collects
    '{1'b0,1'b0,1'b0,11'h000, 1'b1,1'b1,1'b0,11'h7FE, 1'b0,1'b1, 4'd3},  // R3 B posts
    '{1'b1,1'b0,1'b1,11'h7FF, 1'b0,1'b0,1'b0,11'h000, 1'b0,1'b1, 4'd9},  // R9 A reads own box
    '{1'b1,1'b1,1'b1,11'h7FE, 1'b0,1'b0,1'b0,11'h000, 1'b0,1'b1, 4'd6},  // R6 A writes peer box
    '{1'b1,1'b0,1'b1,11'h7FD, 1'b0,1'b0,1'b0,11'h000, 1'b0,1'b1, 4'd7},  // R7 neighbour word
    '{1'b1,1'b0,1'b1,11'h7FE, 1'b0,1'b0,1'b0,11'h000, 1'b1,1'b1, 4'd5},  // R5 A collects
    '{1'b0,1'b0,1'b0,11'h000, 1'b0,1'b1,1'b0,11'h7FE, 1'b1,1'b1, 4'd7},  // R7 B post en off
    '{1'b1,1'b1,1'b0,11'h7FD, 1'b0,1'b0,1'b0,11'h000, 1'b1,1'b1, 4'd7},  // R7 A post wrong word
    '{1'b1,1'b1,1'b0,11'h7FF, 1'b1,1'b0,1'b1,11'h7FF, 1'b1,1'b0, 4'd8},  // R8 race, idle flag
    '{1'b1,1'b1,1'b0,11'h7FF, 1'b1,1'b0,1'b1,11'h7FF, 1'b1,1'b0, 4'd8},  // R8 race, pending flag
    '{1'b0,1'b0,1'b0,11'h000, 1'b1,1'b0,1'b1,11'h7FF, 1'b1,1'b1, 4'd4},  // R4 collect again
    '{1'b1,1'b1,1'b0,11'h7FF, 1'b1,1'b1,1'b0,11'h7FE, 1'b0,1'b0, 4'd2},  // R2 + R3 together
    '{1'b1,1'b0,1'b1,11'h7FE, 1'b1,1'b0,1'b1,11'h7FF, 1'b1,1'b1, 4'd5}   // R5 + R4 together
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          a_en, a_we, a_oe, b_en, b_we, b_oe;
  logic [AW-1:0] a_addr, b_addr;
  logic          a_irq_n, b_irq_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  mbx_irq #(.AW(AW)) u_mbx_irq (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_oe(a_oe), .a_addr(a_addr),
    .b_en(b_en), .b_we(b_we), .b_oe(b_oe), .b_addr(b_addr),
    .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
  );

  task automatic check(input logic ea, input logic eb, input int req);
    n_cmp++;
    if (a_irq_n !== ea || b_irq_n !== eb) begin
      n_bad++;
      $display("FAIL R%0d: a_irq_n/b_irq_n = %b%b, expected %b%b", req, a_irq_n, b_irq_n, ea, eb);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    a_en = v.ae; a_we = v.awe; a_oe = v.aoe; a_addr = v.aa;
    b_en = v.be; b_we = v.bwe; b_oe = v.boe; b_addr = v.ba;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst = 1'b1;
    a_en = 0; a_we = 0; a_oe = 0; a_addr = '0;
    b_en = 0; b_we = 0; b_oe = 0; b_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    check(1'b1, 1'b1, 1); // R1 reset state
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      check(TBL[i].exp_a, TBL[i].exp_b, int'(TBL[i].req));
    end

    // R1: reset asserted during a post wins over it
    drive('{1'b1,1'b1,1'b0,11'h7FF, 1'b1,1'b1,1'b0,11'h7FE, 1'b0,1'b0, 4'd2});
    check(1'b0, 1'b0, 2);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(1'b1, 1'b1, 1); // R1 with posts still driven
    @(negedge clk);
    rst = 1'b0;
    a_en = 0; b_en = 0;
    // R10: long idle keeps the idle state
    repeat (5) @(posedge clk);
    #1;
    check(1'b1, 1'b1, 10);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule